// File: doc/BRIEF.md
# Multi-Cycle Memory Access Controller

This block is a synchronous front end placed between a single requester and a memory array. It accepts one word-wide read or write per request, then drives the array's chip select, write enable, read enable, row address and row data until the access is done. The number of cycles an array needs to complete a write or a read is set by parameters. The same logic can therefore serve a fast static array that finishes in one cycle, or a slow non-volatile array that needs the address and strobes held for several cycles.

The array row may be narrower than the requester's word. In that case each access is split into beats, one per row-sized slice. The least significant slice goes first. Each beat uses its own row address: the word address times the beat count, plus the beat index. Read slices are collected into a full word before it is returned. When the row is as wide as the word, there is a single beat and the word address drives the array directly, with no slice select.

The request port follows valid/ready rules. A request transfers on a cycle where both `req_valid` and `req_ready` are high. `req_ready` falls in the cycle after acceptance and stays low until every beat has finished, so the requester must hold its request stable while waiting. Read data comes back with a one-cycle `rsp_valid` pulse. That pulse cannot be back-pressured, so the requester must accept it when it appears.

Top module: `mcm_ctrl`

## Requirements
- R1: `req_ready` is high whenever no access is in progress. It is low from the cycle after acceptance through the last cycle of the last beat. It is high again in the cycle after that.
- R2: A write drives `mem_cs`=1, `mem_we`=1, `mem_re`=0 and the slice for the current beat on `mem_wdata`. Each beat lasts exactly `WR_LAT` cycles.
- R3: A read drives `mem_cs`=1, `mem_re`=1, `mem_we`=0. Each beat lasts exactly `RD_LAT` cycles. `mem_rdata` is sampled only in the last cycle of each beat window.
- R4: Beat b (0 first) carries bits [b*ROW_W +: ROW_W] of the word, at row address `req_addr*BEATS + b`, where BEATS = WORD_W/ROW_W.
- R5: `mem_cs`, `mem_we` and `mem_re` do not change while an access is in progress. All three are low in the cycle after the access completes and whenever the controller is idle.
- R6: After a read completes, `rsp_valid` is high for exactly one cycle (the cycle after the last beat), carrying the assembled word on `rsp_rdata`. `rsp_valid` never rises for a write.
- R7: With ROW_W equal to WORD_W, each access is a single beat and `mem_addr` equals `req_addr` with no slice select.
- R8: After reset, `req_ready`=1 and `mem_cs`, `mem_we`, `mem_re` and `rsp_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | WORD_W | Write word |
| rsp_valid | output | 1 | One-cycle pulse: read word available |
| rsp_rdata | output | WORD_W | Assembled read word |
| mem_cs | output | 1 | Array chip select |
| mem_we | output | 1 | Array write enable |
| mem_re | output | 1 | Array read enable |
| mem_addr | output | ADDR_W+log2(BEATS) | Row address |
| mem_wdata | output | ROW_W | Row write data |
| mem_rdata | input | ROW_W | Row read data |

## Verification
The hardest case to reach from the ports is a controller that samples read data one cycle early or late inside a multi-cycle beat window. A plain array would return the right value anyway. The bench memory model therefore returns the inverted row value in every cycle of a window except the last, and commits a write only in the last cycle of its window. Any timing slip then shows up as a wrong word. Randomly mixed reads and writes, issued back to back on a small address space, make reads often return data written a few accesses earlier. They also make one access start in the cycle right after another one finishes.

// File: rtl/mcm_pkg.sv
package mcm_pkg;
  typedef enum logic { ST_IDLE = 1'b0, ST_BUSY = 1'b1 } mcm_state_e;

  function automatic int mcm_sel_w(input int beats);
    return (beats > 1) ? $clog2(beats) : 1;
  endfunction
endpackage

// File: rtl/mcm_lat_timer.sv
module mcm_lat_timer #(
  parameter int WR_LAT = 3,
  parameter int RD_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic step,
  input  logic is_write,
  output logic last
);
  localparam int MAXL = (WR_LAT > RD_LAT) ? WR_LAT : RD_LAT;
  localparam int CW   = (MAXL > 1) ? $clog2(MAXL) : 1;

  logic [CW-1:0] cnt;

  assign last = is_write ? (cnt == CW'(WR_LAT - 1)) : (cnt == CW'(RD_LAT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= '0;
    else if (step) begin
      if (last)          cnt <= '0;
      else               cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mcm_slice_mux.sv
module mcm_slice_mux #(
  parameter int WORD_W = 32,
  parameter int ROW_W  = 8,
  parameter int SEL_W  = 2
) (
  input  logic [WORD_W-1:0] word,
  input  logic [SEL_W-1:0]  sel,
  output logic [ROW_W-1:0]  slice
);
  localparam int BEATS = WORD_W / ROW_W;

  generate
    if (BEATS == 1) begin : g_full
      logic unused_sel;
      assign unused_sel = ^sel;
      assign slice = word;
    end else begin : g_split
      assign slice = word[sel*ROW_W +: ROW_W];
    end
  endgenerate
endmodule

// File: rtl/mcm_word_asm.sv
module mcm_word_asm #(
  parameter int WORD_W = 32,
  parameter int ROW_W  = 8,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [SEL_W-1:0]  sel,
  input  logic [ROW_W-1:0]  din,
  output logic [WORD_W-1:0] word
);
  localparam int BEATS = WORD_W / ROW_W;

  generate
    for (genvar b = 0; b < BEATS; b++) begin : g_slot
      logic [ROW_W-1:0] slot_q;
      always_ff @(posedge clk) begin
        if (!rst_n)                                 slot_q <= '0;
        else if (capture && (sel == SEL_W'(b)))     slot_q <= din;
      end
      assign word[b*ROW_W +: ROW_W] = slot_q;
    end
  endgenerate
endmodule

// File: rtl/mcm_ctrl.sv
module mcm_ctrl
  import mcm_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 32,
  parameter int ROW_W  = 8,
  parameter int WR_LAT = 3,
  parameter int RD_LAT = 2,
  localparam int BEATS = WORD_W / ROW_W,
  localparam int COL_W = (BEATS > 1) ? $clog2(BEATS) : 0,
  localparam int MA_W  = ADDR_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              mem_cs,
  output logic              mem_we,
  output logic              mem_re,
  output logic [MA_W-1:0]   mem_addr,
  output logic [ROW_W-1:0]  mem_wdata,
  input  logic [ROW_W-1:0]  mem_rdata
);
  localparam int SEL_W = mcm_sel_w(BEATS);

  mcm_state_e        state;
  logic              op_write;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q;
  logic [SEL_W-1:0]  beat;
  logic              busy, accept, beat_last, final_beat;

  assign busy       = (state == ST_BUSY);
  assign req_ready  = (state == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign final_beat = (beat == SEL_W'(BEATS - 1));

  mcm_lat_timer #(.WR_LAT(WR_LAT), .RD_LAT(RD_LAT)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(accept), .step(busy),
    .is_write(op_write), .last(beat_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      op_write  <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      beat      <= '0;
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept) begin
        state    <= ST_BUSY;
        op_write <= req_write;
        addr_q   <= req_addr;
        wdata_q  <= req_wdata;
        beat     <= '0;
      end else if (busy && beat_last) begin
        if (final_beat) begin
          state     <= ST_IDLE;
          rsp_valid <= !op_write;
        end else begin
          beat <= beat + 1'b1;
        end
      end
    end
  end

  assign mem_cs = busy;
  assign mem_we = busy && op_write;
  assign mem_re = busy && !op_write;

  generate
    if (BEATS > 1) begin : g_col
      assign mem_addr = {addr_q, beat};
    end else begin : g_nocol
      assign mem_addr = addr_q;
    end
  endgenerate

  mcm_slice_mux #(.WORD_W(WORD_W), .ROW_W(ROW_W), .SEL_W(SEL_W)) u_mux (
    .word(wdata_q), .sel(beat), .slice(mem_wdata)
  );

  mcm_word_asm #(.WORD_W(WORD_W), .ROW_W(ROW_W), .SEL_W(SEL_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .capture(busy && beat_last && !op_write),
    .sel(beat), .din(mem_rdata), .word(rsp_rdata)
  );
endmodule

// File: rtl/mcm_ctrl_checker.sv
module mcm_ctrl_checker (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_valid,
  input logic mem_cs,
  input logic mem_we,
  input logic mem_re
);
  assert_ready_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_we_re_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  assert_enables_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |->
      ($stable(mem_cs) && $stable(mem_we) && $stable(mem_re)));

  assert_cs_with_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs == !req_ready);

  assert_rsp_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (req_ready && $past(mem_re) && $past(!req_ready)));

  assert_rsp_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind mcm_ctrl mcm_ctrl_checker u_mcm_ctrl_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .mem_cs(mem_cs), .mem_we(mem_we), .mem_re(mem_re)
);

// File: tb/mcm_ctrl_bench.sv
module mcm_bench_mem #(
  parameter int AW     = 6,
  parameter int DW     = 8,
  parameter int WR_LAT = 3,
  parameter int RD_LAT = 2
) (
  input  logic          clk,
  input  logic          cs,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [1<<AW];
  logic [AW-1:0] prev_addr;
  logic          prev_cs;
  int            run;
  int            held;

  initial begin
    for (int i = 0; i < (1<<AW); i++) mem[i] = '0;
    prev_addr = '0;
    prev_cs   = 1'b0;
    run       = 0;
  end

  // cycles the current address has already been presented before this one
  assign held  = (cs && prev_cs && addr == prev_addr) ? run + 1 : 0;
  assign rdata = (cs && re) ? ((held == RD_LAT - 1) ? mem[addr] : ~mem[addr]) : '0;

  always @(posedge clk) begin
    if (cs && we && held == WR_LAT - 1) mem[addr] <= wdata;
    run       <= held;
    prev_addr <= addr;
    prev_cs   <= cs;
  end
endmodule

module mcm_ctrl_bench;
  localparam int AW = 4, WW = 32, RW = 8, WL = 3, RL = 2;
  localparam int NB = WW / RW;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [WW-1:0] ref_mem [1<<AW];

  // main instance: narrow rows, slow array
  logic req_valid = 0, req_write = 0, req_ready, rsp_valid;
  logic [AW-1:0] req_addr = '0;
  logic [WW-1:0] req_wdata = '0, rsp_rdata;
  logic mem_cs, mem_we, mem_re;
  logic [AW+1:0] mem_addr;
  logic [RW-1:0] mem_wdata, mem_rdata;

  mcm_ctrl #(.ADDR_W(AW), .WORD_W(WW), .ROW_W(RW), .WR_LAT(WL), .RD_LAT(RL)) u_mcm_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_cs(mem_cs), .mem_we(mem_we),
    .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );
  mcm_bench_mem #(.AW(AW+2), .DW(RW), .WR_LAT(WL), .RD_LAT(RL)) u_mem (
    .clk(clk), .cs(mem_cs), .we(mem_we), .re(mem_re), .addr(mem_addr),
    .wdata(mem_wdata), .rdata(mem_rdata)
  );

  // second instance: row as wide as word, single-cycle array
  logic f_valid = 0, f_write = 0, f_ready, f_rsp;
  logic [AW-1:0] f_addr = '0, f_maddr;
  logic [WW-1:0] f_wdata = '0, f_rdata, f_mwdata, f_mrdata;
  logic f_cs, f_we, f_re;

  mcm_ctrl #(.ADDR_W(AW), .WORD_W(WW), .ROW_W(WW), .WR_LAT(1), .RD_LAT(1)) u_mcm_ctrl_full (
    .clk(clk), .rst_n(rst_n), .req_valid(f_valid), .req_ready(f_ready),
    .req_write(f_write), .req_addr(f_addr), .req_wdata(f_wdata),
    .rsp_valid(f_rsp), .rsp_rdata(f_rdata), .mem_cs(f_cs), .mem_we(f_we),
    .mem_re(f_re), .mem_addr(f_maddr), .mem_wdata(f_mwdata), .mem_rdata(f_mrdata)
  );
  mcm_bench_mem #(.AW(AW), .DW(WW), .WR_LAT(1), .RD_LAT(1)) u_mem_full (
    .clk(clk), .cs(f_cs), .we(f_we), .re(f_re), .addr(f_maddr),
    .wdata(f_mwdata), .rdata(f_mrdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [RW-1:0] slice_of(input logic [WW-1:0] w, input int b);
    return w[b*RW +: RW];
  endfunction

  function automatic logic [AW+1:0] row_of(input logic [AW-1:0] a, input int b);
    return (AW+2)'(a) * NB + (AW+2)'(b);
  endfunction

  // called at a negedge while the controller is idle; returns at the negedge after completion
  task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [WW-1:0] d);
    int lat;
    lat = wr ? WL : RL;
    req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
    chk(req_ready === 1'b1, "R1 ready idle", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    for (int b = 0; b < NB; b++) begin
      for (int c = 0; c < lat; c++) begin
        chk(req_ready === 1'b0, "R1 ready busy", req_ready, 0);
        chk(mem_cs === 1'b1 && mem_we === wr && mem_re === !wr, "R5 enables held",
            {mem_cs, mem_we, mem_re}, {1'b1, wr, !wr});
        chk(mem_addr === row_of(a, b), "R4 row address", mem_addr, row_of(a, b));
        if (wr) chk(mem_wdata === slice_of(d, b), "R2 write slice", mem_wdata, slice_of(d, b));
        else    chk(rsp_valid === 1'b0, "R6 no early rsp", rsp_valid, 0);
        @(negedge clk);
      end
    end
    chk(req_ready === 1'b1, "R1 ready back", req_ready, 1);
    chk({mem_cs, mem_we, mem_re} === 3'b000, "R5 enables drop", {mem_cs, mem_we, mem_re}, 0);
    chk(rsp_valid === !wr, wr ? "R6 no rsp on write" : "R6 rsp pulse", rsp_valid, !wr);
    if (!wr) chk(rsp_rdata === ref_mem[a], "R3 read word", rsp_rdata, ref_mem[a]);
    else     ref_mem[a] = d;
  endtask

  task automatic full_op(input bit wr, input logic [AW-1:0] a, input logic [WW-1:0] d,
                         input logic [WW-1:0] exp);
    f_write = wr; f_addr = a; f_wdata = d; f_valid = 1'b1;
    @(negedge clk);
    f_valid = 1'b0;
    chk(f_maddr === a, "R7 direct address", f_maddr, a);
    chk(f_cs === 1'b1 && f_ready === 1'b0, "R7 single beat busy", {f_cs, f_ready}, 2'b10);
    if (wr) chk(f_mwdata === d, "R7 full row data", f_mwdata, d);
    @(negedge clk);
    chk(f_ready === 1'b1 && f_cs === 1'b0, "R7 single beat done", {f_ready, f_cs}, 2'b10);
    if (!wr) chk(f_rsp === 1'b1 && f_rdata === exp, "R7 full read", f_rdata, exp);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < (1<<AW); i++) ref_mem[i] = '0;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1 && {mem_cs, mem_we, mem_re, rsp_valid} === 4'b0, "R8 reset state",
        {req_ready, mem_cs, mem_we, mem_re, rsp_valid}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1 && {mem_cs, mem_we, mem_re, rsp_valid} === 4'b0, "R8 after reset",
        {req_ready, mem_cs, mem_we, mem_re, rsp_valid}, 5'b10000);

    // directed corners: extreme addresses and data, back-to-back read after write
    do_op(1'b0, 4'd0, '0);
    do_op(1'b1, 4'd15, 32'hFFFF_FFFF);
    do_op(1'b0, 4'd15, '0);
    do_op(1'b1, 4'd0, 32'h8000_0001);
    do_op(1'b1, 4'd1, 32'h1234_5678);
    do_op(1'b0, 4'd0, '0);
    do_op(1'b0, 4'd1, '0);
    do_op(1'b1, 4'd1, 32'hA5C3_0F96);
    do_op(1'b0, 4'd1, '0);

    // constrained random mix
    for (int n = 0; n < 300; n++) begin
      logic [AW-1:0] a;
      bit wr;
      a  = AW'($urandom % (1<<AW));
      wr = ($urandom % 5) < 2;
      do_op(wr, a, $urandom);
      if ($urandom % 4 == 0) @(negedge clk);
    end

    // full-width row instance
    full_op(1'b1, 4'd9, 32'hDEAD_BEEF, '0);
    @(negedge clk);
    full_op(1'b1, 4'd2, 32'h0BAD_F00D, '0);
    @(negedge clk);
    full_op(1'b0, 4'd9, '0, 32'hDEAD_BEEF);
    @(negedge clk);
    full_op(1'b0, 4'd2, '0, 32'h0BAD_F00D);
    full_op(1'b0, 4'd5, '0, 32'h0);

    finish_run();
  end
endmodule